// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block gathers the level-sensitive interrupt pins of the devices on a shared PCI bus and delivers them to a sixteen-input legacy interrupt controller. Each device has four pins, INTA to INTD. Before the pins are merged, they are rotated by the device's slot position. This spreads the load so that the INTA pins of neighbouring slots land on different shared lines. The rotated pins are ORed into four shared lines, PIRQ0 to PIRQ3.

Four one-byte steering registers are written over a byte-enabled configuration port. Each register either names the controller input that its shared line drives or turns that line off. Each controller input is driven high while any enabled shared line steered to it is high. The steering is applied again, in full, whenever a register changes. A line that is switched on, or moved to another input, therefore shows its present level on its new target straight away.

Top module: `pirq_router`

## Requirements
- R1: After a synchronous active-low reset, all four steering bytes hold 0x80. Every line is then switched off, and `irq_out` stays all zero even while device pins are asserted.
- R2: Pin `i` of slot `s` (bit `s*4+i` of `dev_int`, i = 0..3 for INTA..INTD) feeds shared line `(i + s + 3) mod 4`, which is `(i + (s - 1)) mod 4`.
- R3: A shared line is high when any device pin that rotates onto it is high. It stays high until the last such pin drops.
- R4: A write with `cfg_we` high and `cfg_addr` equal to 0x60 updates the steering bytes. Byte lane `p` (`cfg_wdata[8p+7:8p]`) is the byte at 0x60+p and steers shared line `p`.
- R5: Only the lanes whose `cfg_be` bit is set are written. The other steering bytes keep their values.
- R6: A steering byte of 16 or more switches its line off. A line that is off drives no output whatever its level. Value 15 still steers to input 15.
- R7: `irq_out[k]` is the OR of the levels of every enabled shared line whose steering byte equals k.
- R8: Two or more lines steered to the same input share it by OR. The input stays high until every one of those lines is low.
- R9: `irq_out` changes only at a clock edge. A pin change or a steering write sampled at one edge shows on `irq_out` right after that edge, and not before it.
- R10: Writes with any other `cfg_addr`, including 0x61, 0x5C and 0x64, change no steering byte.
- R11: When a steering byte is rewritten, every output is recomputed from the present line levels. The old target drops and the new target rises at the same edge. A line that is switched back on shows its current level at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Dword-aligned configuration byte address |
| cfg_wdata | input | 32 | Write data, one byte per lane |
| cfg_be | input | 4 | Byte enables, one per lane |
| dev_int | input | NUM_SLOTS*4 | Device interrupt pin levels, bit s*4+i is pin i of slot s |
| irq_out | output | 16 | Level outputs to the interrupt controller |

## Verification
Single-pin sweeps cover every slot and pin, one at a time. These separate a wrong rotation offset from a wrong direction, because each pin lights exactly one distinct output. Several pins on one shared line, and several lines steered to one input, are raised and then dropped one by one. This exposes an AND where an OR belongs, and any state that lingers after a drop. Partial-enable writes, writes to neighbouring addresses and steering values of 15, 16 and 0xFF exercise the decode boundaries. A pseudo-random pin pattern run against a model of the steering rules checks the merged behaviour.

// File: rtl/pirq_router_pkg.sv
// Shared constants and types for the PCI interrupt pin router.
// Assumes one steering byte per shared line, with all lines in one dword.
package pirq_router_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] steer_t;
    localparam steer_t STEER_RESET = 8'h80;
endpackage

// File: rtl/pirq_rotate.sv
// Rotates each slot's four pins by slot position and ORs them per shared line.
// Assumes pin i of slot s sits at bit s*NUM_PIRQ+i and feeds line (i+s-1) mod NUM_PIRQ.
module pirq_rotate #(
    parameter int unsigned NUM_PIRQ  = 4,
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned PIN_W    = NUM_PIRQ * NUM_SLOTS
) (
    input  logic [PIN_W-1:0]    dev_int,
    output logic [NUM_PIRQ-1:0] pirq_lvl
);
    // Merge every pin whose rotated index lands on line p.
    always_comb begin
        pirq_lvl = '0;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                for (int i = 0; i < NUM_PIRQ; i++) begin
                    if (((i + s + NUM_PIRQ - 1) % NUM_PIRQ) == p) begin
                        pirq_lvl[p] = pirq_lvl[p] | dev_int[s*NUM_PIRQ + i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pirq_steer_regs.sv
// Holds the steering bytes, written through a byte-enabled dword port.
// Assumes lane p of the dword at ROUTE_BASE is the byte for line p.
// Exposes the next value so that the level map can use a write at the edge where it lands.
module pirq_steer_regs
    import pirq_router_pkg::*;
#(
    parameter int unsigned NUM_PIRQ   = 4,
    parameter logic [7:0]  ROUTE_BASE = 8'h60,
    localparam int unsigned DATA_W    = NUM_PIRQ * BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [7:0]                    cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    input  logic [NUM_PIRQ-1:0]           cfg_be,
    output logic [NUM_PIRQ-1:0][BYTE_W-1:0] steer_q,
    output logic [NUM_PIRQ-1:0][BYTE_W-1:0] steer_d
);
    logic hit;

    // Decode a write to the steering dword.
    assign hit = cfg_we && (cfg_addr == ROUTE_BASE);

    // Merge the enabled lanes of the write into the held bytes.
    always_comb begin
        steer_d = steer_q;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (hit && cfg_be[p]) begin
                steer_d[p] = cfg_wdata[p*BYTE_W +: BYTE_W];
            end
        end
    end

    // Hold the steering bytes; reset switches every line off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PIRQ; p++) begin
                steer_q[p] <= STEER_RESET;
            end
        end else begin
            steer_q <= steer_d;
        end
    end
endmodule

// File: rtl/pirq_level_map.sv
// Keeps a level map with one bit per (controller input, shared line) pair, at index k*NUM_PIRQ+p.
// The map is rebuilt every cycle from the steering and the line levels. A steering change and
// a level change therefore take effect at the same edge. Each output ORs its group of map bits.
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 4,
    parameter int unsigned NUM_IRQ  = 16,
    localparam int unsigned MAP_W   = NUM_IRQ * NUM_PIRQ
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PIRQ-1:0][BYTE_W-1:0] steer,
    input  logic [NUM_PIRQ-1:0]             pirq_lvl,
    output logic [NUM_IRQ-1:0]              irq_out
);
    logic [MAP_W-1:0] map_d;
    logic [MAP_W-1:0] map_q;

    // Set the bit of each line at its target; an out-of-range byte matches no input.
    always_comb begin
        for (int k = 0; k < NUM_IRQ; k++) begin
            for (int p = 0; p < NUM_PIRQ; p++) begin
                map_d[k*NUM_PIRQ + p] = pirq_lvl[p] && (steer[p] == BYTE_W'(k));
            end
        end
    end

    // Register the map; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    // Reduce each controller input's group of map bits.
    generate
        for (genvar k = 0; k < NUM_IRQ; k++) begin : g_out
            assign irq_out[k] = |map_q[k*NUM_PIRQ +: NUM_PIRQ];
        end
    endgenerate
endmodule

// File: rtl/pirq_router.sv
// Top of the PCI interrupt pin router. It rotates the device pins onto the shared lines,
// holds the steering bytes and drives the registered controller inputs.
// Assumes NUM_PIRQ steering bytes fit in the single dword at ROUTE_BASE.
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int unsigned NUM_PIRQ   = 4,
    parameter int unsigned NUM_IRQ    = 16,
    parameter int unsigned NUM_SLOTS  = 8,
    parameter logic [7:0]  ROUTE_BASE = 8'h60,
    localparam int unsigned PIN_W     = NUM_PIRQ * NUM_SLOTS,
    localparam int unsigned DATA_W    = NUM_PIRQ * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [NUM_PIRQ-1:0] cfg_be,
    input  logic [PIN_W-1:0]    dev_int,
    output logic [NUM_IRQ-1:0]  irq_out
);
    logic [NUM_PIRQ-1:0]             pirq_lvl;
    logic [NUM_PIRQ-1:0][BYTE_W-1:0] steer_q;
    logic [NUM_PIRQ-1:0][BYTE_W-1:0] steer_d;

    pirq_rotate #(.NUM_PIRQ(NUM_PIRQ), .NUM_SLOTS(NUM_SLOTS)) u_rotate (
        .dev_int  (dev_int),
        .pirq_lvl (pirq_lvl)
    );

    pirq_steer_regs #(.NUM_PIRQ(NUM_PIRQ), .ROUTE_BASE(ROUTE_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_be    (cfg_be),
        .steer_q   (steer_q),
        .steer_d   (steer_d)
    );

    pirq_level_map #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .steer    (steer_d),
        .pirq_lvl (pirq_lvl),
        .irq_out  (irq_out)
    );
endmodule

// File: rtl/pirq_router_chk.sv
// Property checker for the pin router, bound to each instance of the top module.
// It reads the held steering bytes and the merged line levels next to the ports.
module pirq_router_chk
    import pirq_router_pkg::*;
#(
    parameter int unsigned NUM_PIRQ   = 4,
    parameter int unsigned NUM_IRQ    = 16,
    parameter logic [7:0]  ROUTE_BASE = 8'h60
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cfg_we,
    input logic [7:0]                      cfg_addr,
    input logic [NUM_PIRQ-1:0]             cfg_be,
    input logic [NUM_IRQ-1:0]              irq_out,
    input logic [NUM_PIRQ-1:0][BYTE_W-1:0] steer_q,
    input logic [NUM_PIRQ-1:0]             pirq_lvl
);
    logic all_off;
    logic [NUM_IRQ-1:0][NUM_PIRQ-1:0] sel;

    // Flag when every line is switched off.
    always_comb begin
        all_off = 1'b1;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (steer_q[p] < BYTE_W'(NUM_IRQ)) all_off = 1'b0;
        end
    end

    // Mark which lines each controller input currently listens to.
    always_comb begin
        for (int k = 0; k < NUM_IRQ; k++) begin
            for (int p = 0; p < NUM_PIRQ; p++) begin
                sel[k][p] = (steer_q[p] == BYTE_W'(k));
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0));

    assert_foreign_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && (cfg_addr == ROUTE_BASE)) |=> $stable(steer_q));

    assert_lines_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> (irq_out == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && $stable(pirq_lvl)) |=> $stable(irq_out));

    generate
        for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_lane
            assert_lane_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && !cfg_be[p]) |=> $stable(steer_q[p]));
        end
        for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
            assert_output_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (irq_out[k] == |(sel[k] & $past(pirq_lvl))));
        end
    endgenerate
endmodule

bind pirq_router pirq_router_chk #(
    .NUM_PIRQ   (NUM_PIRQ),
    .NUM_IRQ    (NUM_IRQ),
    .ROUTE_BASE (ROUTE_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_be   (cfg_be),
    .irq_out  (irq_out),
    .steer_q  (steer_q),
    .pirq_lvl (pirq_lvl)
);

// File: tb/pirq_router_bench.sv
// Directed bench for the pin router: one task per scenario, with a model built from the requirements.
module pirq_router_bench;
    localparam int NP = 4;
    localparam int NI = 16;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [3:0]    cfg_be = '0;
    logic [NS*NP-1:0] dev_int = '0;
    logic [NI-1:0] irq_out;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_steer [NP];

    always #4 clk = ~clk;

    pirq_router u_pirq_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .dev_int(dev_int), .irq_out(irq_out)
    );

    function automatic logic [NI-1:0] model_out();
        logic [NP-1:0] lvl = '0;
        logic [NI-1:0] o = '0;
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < NP; i++)
                if (dev_int[s*NP+i]) lvl[(i + s + 3) % 4] = 1'b1;
        for (int p = 0; p < NP; p++)
            if (m_steer[p] < 8'd16 && lvl[p]) o[m_steer[p][3:0]] = 1'b1;
        return o;
    endfunction

    task automatic check(string req, logic [NI-1:0] exp);
        checks++;
        if (irq_out !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, irq_out, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        step();
        cfg_we = 1'b0; cfg_be = '0;
        if (a == 8'h60)
            for (int p = 0; p < NP; p++)
                if (be[p]) m_steer[p] = d[p*8 +: 8];
    endtask

    task automatic t_reset();
        dev_int = '1;
        repeat (3) step();
        rst_n = 1'b1;
        for (int p = 0; p < NP; p++) m_steer[p] = 8'h80;
        step();
        check("R1 reset quiet", 16'h0000);
        step();
        check("R1 reset quiet later", model_out());
        dev_int = '0;
        step();
    endtask

    task automatic t_timing();
        cfg_write(8'h60, 32'h0000_0003, 4'b0001);
        dev_int[4] = 1'b1;
        #1 check("R9 no change before edge", 16'h0000);
        step();
        check("R9 R4 line 0 to input 3", 16'h0008);
        dev_int[4] = 1'b0;
        #1 check("R9 held before edge", 16'h0008);
        step();
        check("R9 drop after edge", 16'h0000);
    endtask

    task automatic t_rotation();
        cfg_write(8'h60, 32'h0706_0504, 4'b1111);
        for (int s = 0; s < NS; s++) begin
            for (int i = 0; i < NP; i++) begin
                dev_int = '0;
                dev_int[s*NP+i] = 1'b1;
                step();
                check("R2 rotation", 16'(1) << (4 + ((i + s + 3) % 4)));
            end
        end
        dev_int = '0;
        step();
    endtask

    task automatic t_pin_or();
        dev_int[1] = 1'b1; dev_int[4] = 1'b1; dev_int[11] = 1'b1;
        step();
        check("R3 three pins on line 0", 16'h0010);
        dev_int[1] = 1'b0;
        step();
        check("R3 two pins remain", 16'h0010);
        dev_int[4] = 1'b0;
        step();
        check("R3 one pin remains", 16'h0010);
        dev_int[11] = 1'b0;
        step();
        check("R3 all pins low", 16'h0000);
    endtask

    task automatic t_share();
        cfg_write(8'h60, 32'h0000_0909, 4'b0011);
        dev_int[4] = 1'b1; dev_int[5] = 1'b1;
        step();
        check("R8 two lines on input 9", 16'h0200);
        dev_int[4] = 1'b0;
        step();
        check("R8 one line remains", 16'h0200);
        dev_int[5] = 1'b0;
        step();
        check("R8 both low", 16'h0000);
    endtask

    task automatic t_byte_enable();
        cfg_write(8'h60, 32'h0C0C_0C0C, 4'b0100);
        dev_int[7:4] = 4'b1111;
        step();
        check("R5 only lane 2 written", 16'h1280);
        check("R5 model agrees", model_out());
    endtask

    task automatic t_disable();
        cfg_write(8'h60, 32'h0010_0000, 4'b0100);
        check("R6 value 16 disables", 16'h0280);
        cfg_write(8'h60, 32'h000F_0000, 4'b0100);
        check("R6 value 15 steers", 16'h8280);
        cfg_write(8'h60, 32'h00FF_0000, 4'b0100);
        check("R6 value 0xFF disables", 16'h0280);
    endtask

    task automatic t_foreign();
        cfg_write(8'h64, 32'h0000_0000, 4'b1111);
        check("R10 write at 0x64", 16'h0280);
        cfg_write(8'h5C, 32'h0000_0000, 4'b1111);
        check("R10 write at 0x5C", 16'h0280);
        cfg_write(8'h61, 32'h0000_0000, 4'b1111);
        check("R10 write at 0x61", 16'h0280);
    endtask

    task automatic t_reroute();
        cfg_write(8'h60, 32'h0100_0000, 4'b1000);
        check("R11 line 3 moved from 7 to 1", 16'h0202);
        cfg_write(8'h60, 32'h0002_0000, 4'b0100);
        check("R11 re-enabled line shows level", 16'h0206);
        dev_int = '0;
        step();
        check("R11 all low", 16'h0000);
    endtask

    task automatic t_mixed();
        logic [31:0] lfsr = 32'hACE1_2B3D;
        cfg_write(8'h60, 32'h0B0B_0E03, 4'b1111);
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            dev_int = lfsr & (lfsr >> 7);
            step();
            check("R7 mixed pattern", model_out());
        end
        dev_int = '0;
        step();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_timing();
        t_rotation();
        t_pin_or();
        t_share();
        t_byte_enable();
        t_disable();
        t_foreign();
        t_reroute();
        t_mixed();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule